// File: doc/BRIEF.md
# Page-to-Port DMA Transfer Engine

This block moves one page of CPU address space (256 bytes by default) to a single fixed destination address, one byte at a time. Software arms it by presenting a page number on the trigger input. Arming alone does nothing on the bus. The engine waits for the CPU to begin its next read. It lets that read run to completion and then takes the bus.

For every byte the engine performs a read from the page, at the address formed by the page number in the upper bits and the byte index in the lower bits. It then performs a write of that byte to the fixed port address. Every bus access occupies a fixed number of clocks, so one byte costs two accesses. While the engine owns the bus, it raises a stall output that holds the CPU off, and the CPU's own bus signals are not forwarded. At all other times the CPU's address, strobes and write data pass straight through to the bus.

Top module: `page_dma_engine`

## Requirements
- R1: A cycle with `trig_valid` high records `trig_page` and marks a transfer as pending. The engine then issues no bus access of its own and `dma_busy` stays low until a CPU read begins.
- R2: A pending transfer is taken up only by a cycle with `cpu_rd` high while the engine is idle. That CPU read keeps the bus for ACC_CYCLES (12) clocks counted from the `cpu_rd` cycle with `dma_busy` low, and the first DMA read starts on the clock after those. CPU writes while a transfer is pending pass through and start nothing.
- R3: The pending mark clears when the transfer is taken up. A CPU read after the transfer ends starts no second transfer.
- R4: A transfer moves exactly 256 bytes. The source address is {page, index}, with page in bits 15:8, and the index rises by one from 0 to 255. After the last byte the engine returns to idle.
- R5: Every DMA write goes to address 0x2004.
- R6: Each DMA access holds its strobe (`bus_rd` for a read, `bus_wr` for a write) with a constant address for 12 consecutive clocks, never both strobes at once. A byte therefore takes 24 clocks: 12 for the read, then 12 for the write.
- R7: The data driven on `bus_wdata` throughout the write for byte n equals `bus_rdata` as sampled in the last clock of the read for byte n.
- R8: `dma_busy` is high from the first clock of the first DMA read through the last clock of the last write. During that time CPU address, strobes and write data do not reach the bus.
- R9: A trigger arriving during a transfer becomes a new pending request with its own page. The running transfer keeps its page and byte sequence, and the next CPU read after it ends starts a transfer of the new page.
- R10: After synchronous active-low reset the engine is idle with nothing pending, `dma_busy` is low and the bus carries the CPU signals unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_valid | input | 1 | Arms a transfer for one cycle |
| trig_page | input | 8 | Source page number, sampled with trig_valid |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request, high in the first clock of a CPU read |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| dma_busy | output | 1 | Stall to the CPU while the engine owns the bus |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |

## Verification
The hardest situation to reach is a second trigger that lands in the middle of a running transfer. It must neither bend the current page sequence nor be lost, and it must wait for a fresh CPU read. The stimulus arms page A and starts it with a CPU read. Partway through the byte loop it presents page B and asserts a CPU write that must not leak onto the bus. It checks every remaining byte against page A. After that it issues one more CPU read and checks a full transfer of page B, followed by a further read that must start nothing.

// File: rtl/pdma_pkg.sv
// Package: shared types for the page-to-port DMA engine.
// Assumes: four sequencer phases are enough to describe ownership of the bus.
package pdma_pkg;

    // Sequencer phase: idle, letting the CPU read finish, DMA read, DMA write
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CPU_RD  = 2'd1,
        ST_DMA_RD  = 2'd2,
        ST_DMA_WR  = 2'd3
    } pdma_state_e;

endpackage

// File: rtl/pdma_request.sv
// Module: pdma_request
// Holds an armed-but-not-started request: a pending mark and the page number.
// Assumes: a new trigger in the same cycle as take-up wins, so the fresh
// request is kept pending rather than dropped.
module pdma_request #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic              take,
    output logic              pend,
    output logic [PAGE_W-1:0] pend_page
);

    // Latch the page on a trigger; drop the pending mark on take-up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_page <= '0;
        end else if (trig_valid) begin
            pend      <= 1'b1;
            pend_page <= trig_page;
        end else if (take) begin
            pend      <= 1'b0;
        end
    end

    AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> (pend && pend_page == $past(trig_page))); // R1
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !trig_valid) |=> !pend); // R3

endmodule

// File: rtl/pdma_sequencer.sv
// Module: pdma_sequencer
// Walks the phases of one transfer: waits out the CPU read that took the
// request up, then alternates a timed read of {page,index} and a timed write.
// Assumes: ACC_CYCLES >= 2; the CPU read that takes the request up started
// in the take-up cycle and lasts ACC_CYCLES clocks.
module pdma_sequencer
    import pdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 8,
    parameter int ACC_CYCLES = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_rd,
    input  logic                     pend,
    input  logic [PAGE_W-1:0]        pend_page,
    input  logic [DATA_W-1:0]        bus_rdata,
    output logic                     take,
    output pdma_state_e              state,
    output logic [ADDR_W-PAGE_W-1:0] idx,
    output logic [PAGE_W-1:0]        page,
    output logic [DATA_W-1:0]        data_q
);

    localparam int IDX_W = ADDR_W - PAGE_W;
    localparam int TMR_W = $clog2(ACC_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACC_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

    logic [TMR_W-1:0] tmr;
    logic             acc_end;

    // Take-up happens only from idle on a CPU read while a request waits
    always_comb take = (state == ST_IDLE) && pend && cpu_rd;
    // Last clock of the current timed access
    always_comb acc_end = (tmr == TMR_LAST);

    // Phase, access timer, byte index, active page and data holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            idx    <= '0;
            page   <= '0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state <= ST_CPU_RD;
                        tmr   <= TMR_W'(1);
                        page  <= pend_page;
                        idx   <= '0;
                    end
                end
                ST_CPU_RD: begin
                    if (acc_end) begin
                        state <= ST_DMA_RD;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_DMA_RD: begin
                    if (acc_end) begin
                        data_q <= bus_rdata;
                        state  <= ST_DMA_WR;
                        tmr    <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_DMA_WR: begin
                    if (acc_end) begin
                        tmr <= '0;
                        if (idx == IDX_LAST) begin
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_DMA_RD;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_NO_START_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(pend && cpu_rd)) |=> (state == ST_IDLE)); // R2
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DMA_RD && !acc_end) |=> (state == ST_DMA_RD && $stable(idx))); // R6
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DMA_WR && !acc_end) |=> (state == ST_DMA_WR && $stable(data_q))); // R7
    AST_LAST_BYTE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DMA_WR && acc_end && idx == IDX_LAST) |=> (state == ST_IDLE)); // R4
    AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(page)); // R9

endmodule

// File: rtl/pdma_bus_mux.sv
// Module: pdma_bus_mux
// Chooses who drives the bus: the CPU when the engine is idle or waiting out
// the CPU read, the engine during its own read and write phases.
// Assumes: the destination address is a fixed parameter.
module pdma_bus_mux
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 8,
    parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
    input  pdma_state_e              state,
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-PAGE_W-1:0] idx,
    input  logic [DATA_W-1:0]        data_q,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic                     dma_busy,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic [DATA_W-1:0]        bus_wdata
);

    // Route engine or CPU signals onto the bus according to the phase
    always_comb begin
        dma_busy  = (state == ST_DMA_RD) || (state == ST_DMA_WR);
        bus_addr  = cpu_addr;
        bus_rd    = cpu_rd;
        bus_wr    = cpu_wr;
        bus_wdata = cpu_wdata;
        if (state == ST_DMA_RD) begin
            bus_addr  = {page, idx};
            bus_rd    = 1'b1;
            bus_wr    = 1'b0;
            bus_wdata = data_q;
        end else if (state == ST_DMA_WR) begin
            bus_addr  = DEST_ADDR;
            bus_rd    = 1'b0;
            bus_wr    = 1'b1;
            bus_wdata = data_q;
        end
    end

endmodule

// File: rtl/page_dma_engine.sv
// Module: page_dma_engine (top)
// Copies one page of CPU address space to a fixed port after the CPU's next
// read, one read and one write per byte, stalling the CPU meanwhile.
// Assumes: the CPU honours dma_busy and issues no access while it is high.
module page_dma_engine
    import pdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 8,
    parameter int ACC_CYCLES = 12,
    parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [PAGE_W-1:0] trig_page,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              dma_busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam int IDX_W = ADDR_W - PAGE_W;

    logic              take;
    logic              pend;
    logic [PAGE_W-1:0] pend_page;
    pdma_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] data_q;

    pdma_request #(.PAGE_W(PAGE_W)) u_req (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_page(trig_page),
        .take(take), .pend(pend), .pend_page(pend_page)
    );

    pdma_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .ACC_CYCLES(ACC_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .pend(pend), .pend_page(pend_page),
        .bus_rdata(bus_rdata), .take(take), .state(state), .idx(idx), .page(page),
        .data_q(data_q)
    );

    pdma_bus_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .DEST_ADDR(DEST_ADDR)
    ) u_mux (
        .state(state), .page(page), .idx(idx), .data_q(data_q),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .dma_busy(dma_busy), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata)
    );

    AST_WRITE_TO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_busy && bus_wr) |-> (bus_addr == DEST_ADDR)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> $onehot({bus_rd, bus_wr})); // R6

endmodule

// File: tb/page_dma_engine_tb.sv
module page_dma_engine_tb;

    localparam int CLK_NS = 8;
    localparam int ACC    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_valid = 1'b0;
    logic [7:0]  trig_page = '0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        dma_busy;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    // Memory model: byte value is a fixed function of the address
    function automatic logic [7:0] mem(input logic [15:0] a);
        return 8'((a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5);
    endfunction
    always_comb bus_rdata = mem(bus_addr);

    page_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_page(trig_page),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .dma_busy(dma_busy), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input logic [7:0] pg);
        @(negedge clk);
        trig_valid = 1'b1;
        trig_page  = pg;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    // Issue a CPU read pulse; returns at the negedge after the cpu_rd cycle
    task automatic cpu_read();
        @(negedge clk);
        cpu_rd   = 1'b1;
        cpu_addr = 16'h8123;
        @(negedge clk);
        cpu_rd   = 1'b0;
    endtask

    // Follow one whole transfer, starting right after cpu_read()
    task automatic follow(input logic [7:0] pg, input int trig_at, input logic [7:0] trig_pg);
        bit ok_cpu = 1;
        bit ok_rd = 1, ok_wr = 1, ok_dat = 1, ok_busy = 1;
        logic [15:0] bad_a = '0;
        logic [7:0] bad_d = '0;
        for (int k = 1; k < ACC; k++) begin
            if (dma_busy) ok_cpu = 0;
            @(negedge clk);
        end
        check(ok_cpu, "R2 CPU read keeps bus 12 clocks", 32'(ok_cpu), 1);
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < ACC; k++) begin
                if (!(bus_rd && !bus_wr && bus_addr == {pg, 8'(b)})) begin
                    ok_rd = 0; bad_a = bus_addr;
                end
                if (!dma_busy) ok_busy = 0;
                @(negedge clk);
            end
            for (int k = 0; k < ACC; k++) begin
                if (b == trig_at && k == 0) begin
                    trig_valid = 1'b1; trig_page = trig_pg;
                    cpu_wr = 1'b1; cpu_addr = 16'h1234; cpu_wdata = 8'h77;
                end else begin
                    trig_valid = 1'b0; cpu_wr = 1'b0;
                end
                if (!(bus_wr && !bus_rd && bus_addr == 16'h2004)) begin
                    ok_wr = 0; bad_a = bus_addr;
                end
                if (bus_wdata != mem({pg, 8'(b)})) begin
                    ok_dat = 0; bad_d = bus_wdata;
                end
                if (!dma_busy) ok_busy = 0;
                @(negedge clk);
            end
            trig_valid = 1'b0; cpu_wr = 1'b0;
        end
        check(ok_rd, "R4 reads {page,index} in order, 12 clocks each (R6)", 32'(bad_a), 32'({pg, 8'h00}));
        check(ok_wr, "R5 writes hit 0x2004, 12 clocks each (R6, R8)", 32'(bad_a), 32'h2004);
        check(ok_dat, "R7 write data equals byte read", 32'(bad_d), 0);
        check(ok_busy, "R8 busy held through transfer", 32'(ok_busy), 1);
        check(!dma_busy, "R4 idle after 256 bytes", 32'(dma_busy), 0);
    endtask

    // Stimulus table: {page, idle gap between trigger and CPU read}
    localparam logic [15:0] VEC [3] = '{ {8'h00, 8'd3}, {8'h3C, 8'd40}, {8'hFF, 8'd0} };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state and passthrough
        cpu_addr = 16'hBEEF; cpu_wr = 1'b1; cpu_wdata = 8'h5A;
        #1;
        check(!dma_busy, "R10 busy low after reset", 32'(dma_busy), 0);
        check(bus_addr == 16'hBEEF && bus_wr && bus_wdata == 8'h5A,
              "R10 CPU signals pass through", 32'(bus_addr), 32'hBEEF);
        cpu_wr = 1'b0;
        cpu_read();
        repeat (20) @(negedge clk);
        check(!dma_busy, "R10 nothing pending after reset", 32'(dma_busy), 0);

        // Table walk
        foreach (VEC[i]) begin
            arm(VEC[i][15:8]);
            repeat (int'(VEC[i][7:0])) @(negedge clk);
            check(!dma_busy, "R1 trigger alone starts nothing", 32'(dma_busy), 0);
            cpu_read();
            follow(VEC[i][15:8], -1, 8'h00);
        end

        // R1/R2: pending request sees CPU writes only
        arm(8'h21);
        repeat (30) @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'h0400; cpu_wdata = 8'h11;
        #1;
        check(bus_wr && bus_addr == 16'h0400 && !dma_busy, "R2 CPU write passes while pending",
              32'(bus_addr), 32'h0400);
        @(negedge clk);
        cpu_wr = 1'b0;
        repeat (20) @(negedge clk);
        check(!dma_busy, "R2 CPU write does not take up request", 32'(dma_busy), 0);

        // R9: trigger page 0x9A mid-transfer of page 0x21
        cpu_read();
        follow(8'h21, 100, 8'h9A);
        cpu_read();
        follow(8'h9A, -1, 8'h00);

        // R3: pending mark gone; another read starts nothing
        cpu_read();
        repeat (40) @(negedge clk);
        check(!dma_busy, "R3 no second transfer without trigger", 32'(dma_busy), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule